// File: doc/BRIEF.md
# Programmable Threshold Offset Sequencer

This block keeps the two programmable thresholds of a dual-clock FIFO: the almost-empty level `n` and the almost-full level `m`. Each threshold is split across a low register, which holds a full data word, and a high register, which holds only the bits needed to reach the FIFO address width. Together that makes four registers. They are reached through one active-low load pin and a two-bit position pointer that moves forward after every access. The low half of `n` comes first, then the high half of `n`, then the low half of `m`, then the high half of `m`. After the fourth position the pointer returns to the first.

Writes are taken on write-clock edges while the load pin and the write enable are both low. Reads are taken on read-clock edges while the load pin and both read enables are low. Reads return the registers in the same rotating order, using a separate pointer kept in the read-clock domain. Neither pointer is cleared when the load pin is released, so a partial programming run can be continued later from where it stopped.

The block works only if the load pin was low while reset was held. If the load pin was high at reset, the pin acts as an ordinary second write enable, and the registers keep their defaults. The assembled `n` and `m` are driven to the write-side flag logic. A copy of `n`, carried across a synchronizer chain, is driven to the read-side flag logic.

Top module: `ofs_seq`

## Requirements
- R1: During a synchronous reset (`rst_n` low), both low registers load 7 and both high registers load 0, so `ae_thresh` and `af_thresh` read 7 after reset. `rd_data` resets to 0.
- R2: Each load write stores `wr_data` into the slot under the write pointer. Slot 0 is the low half of n (`ae_thresh[DW-1:0]`), slot 1 is the high half of n (`ae_thresh[AW-1:DW]`), slot 2 is the low half of m, and slot 3 is the high half of m. A load write is `load_n`=0 and `wen_n`=0 at a `wr_clk` rising edge, in programming mode.
- R3: After slot 3, the next load write goes to slot 0 again.
- R4: With `load_n`=0 and `wen_n`=1, a write-clock edge changes no register and does not move the write pointer.
- R5: With `load_n`=1, no register changes. The write pointer keeps its position, so the next load write goes to the slot after the last one written. Reset returns both pointers to slot 0.
- R6: Each load read puts the slot under the read pointer onto `rd_data` and moves the pointer on, in the same slot order with wrap. A load read is `load_n`=0, `ren_a_n`=0 and `ren_b_n`=0 at a `rd_clk` rising edge, in programming mode. High slots read back zero-extended to DW bits.
- R7: If either read enable is high, or `load_n` is high, `rd_data` holds its value and the read pointer does not move.
- R8: A high register stores only `wr_data[AW-DW-1:0]`. With the defaults, writing 0x1FF to a high slot reads back as 0x07F.
- R9: If `load_n` was high during reset, load writes and load reads have no effect. The thresholds stay at 7 and `rd_data` stays 0.
- R10: `ae_thresh_rd` follows `ae_thresh` through a chain of SYNC_STAGES `rd_clk` flops, and reads 7 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| load_n | input | 1 | Active-low load pin; its level during reset selects programming mode |
| wen_n | input | 1 | Active-low write enable |
| ren_a_n | input | 1 | First active-low read enable |
| ren_b_n | input | 1 | Second active-low read enable |
| wr_data | input | DW | Data written into the selected offset slot |
| rd_data | output | DW | Read-back data from the selected offset slot |
| ae_thresh | output | AW | Almost-empty level n, write-clock domain |
| af_thresh | output | AW | Almost-full level m, write-clock domain |
| ae_thresh_rd | output | AW | Almost-empty level n, resynchronized to the read clock |

## Verification
The assertions assume that a load write and a load read never land on the same pair of edges. The read port samples the write-domain registers directly. They also assume that `load_n` is steady around each reset release, because the mode is captured at that point. The bench drives every write-side input on `wr_clk` falling edges and every read-side input on `rd_clk` falling edges. It always finishes a write run and returns the enables to idle before it starts a read run. The read clock is phase-shifted from the write clock, so no edges coincide. The bench waits for the synchronizer chain to settle before it compares `ae_thresh_rd`.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic [1:0] {
      SL_AE_LO = 2'd0,
      SL_AE_HI = 2'd1,
      SL_AF_LO = 2'd2,
      SL_AF_HI = 2'd3
   } slot_e;

   function automatic slot_e slot_next(input slot_e s);
      logic [1:0] nxt;
      nxt = s + 2'd1;
      return slot_e'(nxt);
   endfunction
endpackage

// File: rtl/ofs_cdc_sync.sv
module ofs_cdc_sync #(
   parameter int W = 16,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_chk
      $error("ofs_cdc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= {STAGES{RST_VAL}};
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
   import ofs_pkg::*;
#(
   parameter int DW = 9,
   parameter int HB = 7,
   parameter logic [DW-1:0] DFLT_LO = 9'd7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_n,
   input  logic            wen_n,
   input  logic [DW-1:0]   wr_data,
   output logic            prog,
   output slot_e           ptr,
   output logic [2*DW-1:0] lo_all,
   output logic [2*HB-1:0] hi_all
);
   logic  prog_q;
   slot_e ptr_q;
   logic  op;

   assign op = prog_q && !load_n && !wen_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q <= ~load_n;
         ptr_q  <= SL_AE_LO;
      end else if (op) begin
         ptr_q <= slot_next(ptr_q);
      end
   end

   // side 0 holds n, side 1 holds m
   for (genvar g = 0; g < 2; g++) begin : g_side
      logic [DW-1:0] lo_q;
      logic [HB-1:0] hi_q;
      logic          we_lo, we_hi;

      assign we_lo = op && (ptr_q == slot_e'(2*g));
      assign we_hi = op && (ptr_q == slot_e'(2*g+1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= DFLT_LO;
            hi_q <= '0;
         end else begin
            if (we_lo) lo_q <= wr_data;
            if (we_hi) hi_q <= wr_data[HB-1:0];
         end
      end

      assign lo_all[g*DW +: DW] = lo_q;
      assign hi_all[g*HB +: HB] = hi_q;
   end

   assign prog = prog_q;
   assign ptr  = ptr_q;
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
   import ofs_pkg::*;
#(
   parameter int DW = 9,
   parameter int HB = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_n,
   input  logic            ren_a_n,
   input  logic            ren_b_n,
   input  logic [2*DW-1:0] lo_all,
   input  logic [2*HB-1:0] hi_all,
   output logic            prog,
   output slot_e           ptr,
   output logic [DW-1:0]   rd_data
);
   logic          prog_q;
   slot_e         ptr_q;
   logic [DW-1:0] dat_q;
   logic [DW-1:0] sel_lo, sel_hi, sel;
   logic [HB-1:0] hi_raw;
   logic          op;

   assign op     = prog_q && !load_n && !ren_a_n && !ren_b_n;
   assign sel_lo = lo_all[ptr_q[1]*DW +: DW];
   assign hi_raw = hi_all[ptr_q[1]*HB +: HB];

   if (HB < DW) begin : g_pad
      assign sel_hi = {{(DW-HB){1'b0}}, hi_raw};
   end else begin : g_full
      assign sel_hi = hi_raw;
   end

   assign sel = ptr_q[0] ? sel_hi : sel_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q <= ~load_n;
         ptr_q  <= SL_AE_LO;
         dat_q  <= '0;
      end else if (op) begin
         dat_q  <= sel;
         ptr_q  <= slot_next(ptr_q);
      end
   end

   assign prog    = prog_q;
   assign ptr     = ptr_q;
   assign rd_data = dat_q;
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
   import ofs_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 16,
   parameter int SYNC_STAGES = 2,
   parameter logic [DW-1:0] DFLT_LO = 9'd7
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          load_n,
   input  logic          wen_n,
   input  logic          ren_a_n,
   input  logic          ren_b_n,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ae_thresh,
   output logic [AW-1:0] af_thresh,
   output logic [AW-1:0] ae_thresh_rd
);
   localparam int HB = AW - DW;
   localparam logic [AW-1:0] DFLT_TH = AW'(DFLT_LO);

   if (AW <= DW || AW > 2*DW) begin : g_chk
      $error("ofs_seq: AW must lie in (DW, 2*DW]");
   end

   logic            wr_prog, rd_prog;
   slot_e           wr_ptr, rd_ptr;
   logic [2*DW-1:0] lo_all;
   logic [2*HB-1:0] hi_all;

   ofs_wr_bank #(.DW(DW), .HB(HB), .DFLT_LO(DFLT_LO)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
      .wr_data(wr_data), .prog(wr_prog), .ptr(wr_ptr),
      .lo_all(lo_all), .hi_all(hi_all)
   );

   ofs_rd_port #(.DW(DW), .HB(HB)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .load_n(load_n), .ren_a_n(ren_a_n),
      .ren_b_n(ren_b_n), .lo_all(lo_all), .hi_all(hi_all),
      .prog(rd_prog), .ptr(rd_ptr), .rd_data(rd_data)
   );

   assign ae_thresh = {hi_all[HB-1:0],    lo_all[DW-1:0]};
   assign af_thresh = {hi_all[2*HB-1:HB], lo_all[2*DW-1:DW]};

   ofs_cdc_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(DFLT_TH)) u_sync (
      .clk(rd_clk), .rst_n(rst_n), .d(ae_thresh), .q(ae_thresh_rd)
   );
endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
   parameter int DW = 9,
   parameter int AW = 16,
   parameter logic [AW-1:0] DFLT_TH = 16'd7
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          load_n,
   input logic          wen_n,
   input logic          ren_a_n,
   input logic          ren_b_n,
   input logic [DW-1:0] rd_data,
   input logic [AW-1:0] ae_thresh,
   input logic [AW-1:0] af_thresh,
   input logic          wr_prog,
   input logic          rd_prog,
   input logic [1:0]    wr_ptr,
   input logic [1:0]    rd_ptr
);
   p_dflt_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ae_thresh == DFLT_TH && af_thresh == DFLT_TH));

   p_rd_dflt_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && rd_ptr == 2'd0));

   p_wptr_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_prog && !load_n && !wen_n) |=> (wr_ptr == 2'($past(wr_ptr) + 2'd1)));

   p_cfg_hold_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (load_n || wen_n) |=> ($stable(ae_thresh) && $stable(af_thresh)));

   p_wptr_hold_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (load_n || wen_n) |=> $stable(wr_ptr));

   p_rptr_step_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_prog && !load_n && !ren_a_n && !ren_b_n) |=> (rd_ptr == 2'($past(rd_ptr) + 2'd1)));

   p_rd_hold_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (load_n || ren_a_n || ren_b_n) |=> ($stable(rd_data) && $stable(rd_ptr)));

   p_mode_off_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_prog |-> (ae_thresh == DFLT_TH && af_thresh == DFLT_TH));
endmodule

bind ofs_seq ofs_seq_chk #(.DW(DW), .AW(AW), .DFLT_TH(DFLT_TH)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
   .wen_n(wen_n), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .rd_data(rd_data),
   .ae_thresh(ae_thresh), .af_thresh(af_thresh), .wr_prog(wr_prog),
   .rd_prog(rd_prog), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_ofs_seq.sv
`timescale 1ns/1ps
module test_ofs_seq;
   localparam int DW = 9;
   localparam int AW = 16;
   localparam int HMASK = (1 << (AW - DW)) - 1;
   localparam int LMASK = (1 << DW) - 1;

   logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic load_n = 1'b0, wen_n = 1'b1, ren_a_n = 1'b1, ren_b_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] ae_thresh, af_thresh, ae_thresh_rd;

   int n_chk = 0, n_bad = 0;
   int exp_lo[2], exp_hi[2];
   int wp, rp, last_rd;
   bit m_prog;
   bit done = 0;

   always #2.5 wr_clk = ~wr_clk;
   initial begin
      #1.2;
      forever #2.5 rd_clk = ~rd_clk;
   end

   ofs_seq #(.DW(DW), .AW(AW)) i_ofs_seq (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
      .wen_n(wen_n), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .wr_data(wr_data),
      .rd_data(rd_data), .ae_thresh(ae_thresh), .af_thresh(af_thresh),
      .ae_thresh_rd(ae_thresh_rd)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int th(input int side);
      return (exp_hi[side] << DW) | exp_lo[side];
   endfunction

   function automatic int slot_val(input int s);
      return (s % 2 == 0) ? exp_lo[s/2] : exp_hi[s/2];
   endfunction

   task automatic chk_th(input string tag);
      chk({tag, " ae"}, int'(ae_thresh), th(0));
      chk({tag, " af"}, int'(af_thresh), th(1));
   endtask

   task automatic wcyc(input logic l, input logic w, input int d);
      @(negedge wr_clk);
      load_n = l; wen_n = w; wr_data = DW'(d);
      @(posedge wr_clk); #1;
      wen_n = 1'b1;
   endtask

   task automatic rcyc(input logic l, input logic a, input logic b);
      @(negedge rd_clk);
      load_n = l; ren_a_n = a; ren_b_n = b;
      @(posedge rd_clk); #1;
      ren_a_n = 1'b1; ren_b_n = 1'b1;
   endtask

   task automatic mw(input int d);
      wcyc(1'b0, 1'b0, d);
      if (m_prog) begin
         if (wp % 2 == 0) exp_lo[wp/2] = d & LMASK;
         else             exp_hi[wp/2] = d & HMASK;
         wp = (wp + 1) % 4;
      end
   endtask

   task automatic mr(input string tag);
      rcyc(1'b0, 1'b0, 1'b0);
      if (m_prog) begin
         last_rd = slot_val(rp);
         rp = (rp + 1) % 4;
      end
      chk(tag, int'(rd_data), last_rd);
   endtask

   task automatic settle_rd();
      repeat (5) @(posedge rd_clk);
      #1;
   endtask

   task automatic do_reset(input logic lvl);
      @(negedge wr_clk);
      rst_n = 1'b0; load_n = lvl; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
      repeat (4) @(posedge wr_clk);
      @(negedge wr_clk);
      rst_n = 1'b1; load_n = 1'b1;
      exp_lo[0] = 7; exp_lo[1] = 7; exp_hi[0] = 0; exp_hi[1] = 0;
      wp = 0; rp = 0; last_rd = 0; m_prog = ~lvl;
      #1;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R1 ae default", int'(ae_thresh), 7);
      chk("R1 af default", int'(af_thresh), 7);
      chk("R1 rd_data reset", int'(rd_data), 0);
      settle_rd();
      chk("R10 ae_thresh_rd default", int'(ae_thresh_rd), 7);
   endtask

   task automatic t_order();
      mw('h1A5); chk_th("R2 slot0");
      mw('h003); chk_th("R2 slot1");
      mw('h0F0); chk_th("R2 slot2");
      mw('h012); chk_th("R2 slot3");
      chk("R2 ae value", int'(ae_thresh), 'h07A5);
      chk("R2 af value", int'(af_thresh), 'h24F0);
   endtask

   task automatic t_wrap();
      mw('h055);
      chk("R3 wrap to ae low", int'(ae_thresh), 'h0655);
      chk("R3 af untouched", int'(af_thresh), 'h24F0);
   endtask

   task automatic t_nop();
      repeat (3) wcyc(1'b0, 1'b1, 'h1FF);
      chk_th("R4 nop hold");
      mw('h021);
      chk("R4 pointer unmoved, slot1 hit", int'(ae_thresh), (('h21) << DW) | 'h055);
   endtask

   task automatic t_resume();
      repeat (3) wcyc(1'b1, 1'b0, 'h1EE);
      chk_th("R5 fifo write ignored");
      mw('h133);
      chk("R5 resume at slot2", int'(af_thresh), ('h12 << DW) | 'h133);
      chk_th("R5 model");
   endtask

   task automatic t_msb();
      mw('h1FF);
      chk("R8 high slot truncated", int'(af_thresh), (HMASK << DW) | 'h133);
   endtask

   task automatic t_readback();
      load_n = 1'b1;
      settle_rd();
      chk("R10 ae_thresh_rd tracks", int'(ae_thresh_rd), th(0));
      mr("R6 read slot0");
      mr("R6 read slot1");
      mr("R6 read slot2");
      mr("R8 read slot3 zero-extended");
      chk("R8 readback value", int'(rd_data), HMASK);
      mr("R6 read wraps to slot0");
   endtask

   task automatic t_ren();
      rcyc(1'b0, 1'b0, 1'b1);
      chk("R7 ren_b high holds", int'(rd_data), last_rd);
      rcyc(1'b0, 1'b1, 1'b0);
      chk("R7 ren_a high holds", int'(rd_data), last_rd);
      rcyc(1'b1, 1'b0, 1'b0);
      chk("R7 load high holds", int'(rd_data), last_rd);
      mr("R7 pointer kept, slot1 next");
   endtask

   task automatic t_mode();
      do_reset(1'b1);
      mw('h0AA); mw('h011); mw('h0BB); mw('h022);
      chk("R9 ae stays default", int'(ae_thresh), 7);
      chk("R9 af stays default", int'(af_thresh), 7);
      rcyc(1'b0, 1'b0, 1'b0);
      rcyc(1'b0, 1'b0, 1'b0);
      chk("R9 rd_data stays zero", int'(rd_data), 0);
   endtask

   initial begin
      t_reset();
      t_order();
      t_wrap();
      t_nop();
      t_resume();
      t_msb();
      t_readback();
      t_ren();
      t_mode();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule